// File: doc/BRIEF.md
# Dual timer/counter unit

This block holds two independent 16-bit up-counting channels behind a small byte-wide register port. Each channel steps either on an internal machine-cycle strobe, one strobe per twelve input clocks, or on falling edges of its own external event pin. The event pin is looked at once per machine cycle. A shared 8-bit configuration register carries one nibble per channel. The nibble selects the counting mode, the count source, and whether an external gate input must also be high before the channel may count.

Software loads and reads the count bytes, sets the run bits and watches the per-channel overflow flags. These flags are also driven onto output pins, so an interrupt controller can pick them up and return an acknowledge. The channel modes are a 13-bit prescaled count, a full 16-bit count, an 8-bit count that reloads from the high byte, and a halt.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset every register reads 0 and both `ovf_flag` bits are 0.
- R2: With the internal source selected, a running channel advances exactly once per CYC_DIV (default 12) clocks. The strobe falls on every CYC_DIV-th rising edge after reset is released, and the count does not change on any other edge.
- R3: Address 0 is the configuration register. Channel n uses bits [4n+3:4n] of it: bits [1:0] of the nibble are the mode, bit 2 selects the external event pin (1) or the internal strobe (0), and bit 3 is the gate enable.
- R4: Address 1 holds the run bit of channel n at bit n. A channel counts only while its run bit is 1. When its gate enable is set, `ext_gate[n]` must also be 1.
- R5: In event mode `ext_evt[n]` is sampled on each machine-cycle strobe. One count is taken when the previous sample was 1 and the current one is 0. A pulse that no strobe sees high is not counted.
- R6: Mode 1 counts {high,low} as 16 bits. FFFFh steps to 0000h and sets the flag.
- R7: Mode 2 counts the low byte only. From FFh the low byte loads the high byte value and sets the flag, and the high byte is unchanged.
- R8: Mode 0 counts a 13-bit value made of the high byte and low bits [4:0]. Low bits [7:5] keep their value. A wrap from high FFh / low 1Fh to zero sets the flag.
- R9: Mode 3 holds the channel's count unchanged.
- R10: Channel 0's low and high bytes sit at addresses 2 and 3, and channel 1's at addresses 4 and 5. A byte write takes effect on the next edge and replaces that channel's count step in that cycle.
- R11: The flag of channel n sits at address 1 bit 4+n. An `ovf_ack[n]` pulse clears it. A write to address 1 loads it from the written bit. An overflow in the same cycle wins over both.
- R12: `ovf_flag[n]` mirrors the flag of channel n. Activity on one channel never alters the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ext_evt | input | 2 | Per-channel external event pins |
| ext_gate | input | 2 | Per-channel external gate inputs |
| ovf_ack | input | 2 | Per-channel overflow acknowledge |
| ovf_flag | output | 2 | Per-channel overflow flags |

## Verification
Two pairs of actions can fall in the same cycle. The first pair is an overflow and a flag clear. The second pair is a count step and a software byte write. The bench counts rising edges from the release of reset, so it knows which edge carries the strobe. It raises `ovf_ack` on a channel loaded with FFFFh on exactly that edge, and expects the flag to remain set and the count to read 0000h. On another strobe edge it writes the low byte, and expects the written value rather than the stepped one. On the following strobe it expects exactly one increment from the written value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;

    typedef enum logic [1:0] {
        MODE_13B     = 2'd0,
        MODE_16B     = 2'd1,
        MODE_RELOAD8 = 2'd2,
        MODE_HALT    = 2'd3
    } tmr_mode_e;

    // one configuration nibble: gate enable is the top bit, mode the bottom two
    typedef struct packed {
        logic      gate_en;
        logic      ext_src;
        tmr_mode_e mode;
    } tmr_cfg_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
        logic              flag;
    } tmr_chan_t;

    typedef struct packed {
        logic [BYTE_W-1:0] cfg;
        logic [1:0]        run;
    } tmr_top_t;

endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
    parameter int CYC_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DIV_W = (CYC_DIV > 1) ? $clog2(CYC_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CYC_DIV - 1);

    logic [DIV_W-1:0] div_d, div_q;

    assign tick_o = (div_q == LAST);

    always_comb begin
        div_d = tick_o ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R2: divider never leaves its range
    a_r2_div_range: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= LAST);

    generate
        if (CYC_DIV > 1) begin : g_gap
            // R2: strobes never come back to back
            a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pin_i,
    output logic fall_o
);
    logic samp_d, samp_q;

    assign fall_o = tick_i & samp_q & ~pin_i;

    always_comb begin
        samp_d = tick_i ? pin_i : samp_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= 1'b0;
        else        samp_q <= samp_d;
    end

    // R5: after a recognised fall the held sample is low
    a_r5_low_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !samp_q);

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_cfg_t          cfg_i,
    input  logic              run_i,
    input  logic              gate_i,
    input  logic              tick_i,
    input  logic              fall_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              flag_wr_i,
    input  logic              flag_wval_i,
    input  logic              ack_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              flag_o
);
    tmr_chan_t cur_d, cur_q;
    logic      step, wrap, wr_any;

    always_comb begin
        cur_d  = cur_q;
        wrap   = 1'b0;
        wr_any = wr_lo_i | wr_hi_i;
        step   = run_i && (!cfg_i.gate_en || gate_i)
                 && (cfg_i.ext_src ? fall_i : tick_i);

        if (wr_any) begin
            if (wr_lo_i) cur_d.lo = wdata_i;
            if (wr_hi_i) cur_d.hi = wdata_i;
        end else if (step) begin
            case (cfg_i.mode)
                MODE_13B: begin
                    if (&cur_q.lo[PRE_W-1:0]) begin
                        cur_d.lo[PRE_W-1:0] = '0;
                        cur_d.hi            = cur_q.hi + 1'b1;
                        wrap                = &cur_q.hi;
                    end else begin
                        cur_d.lo[PRE_W-1:0] = cur_q.lo[PRE_W-1:0] + 1'b1;
                    end
                end
                MODE_16B: begin
                    {cur_d.hi, cur_d.lo} = {cur_q.hi, cur_q.lo} + 1'b1;
                    wrap                 = &{cur_q.hi, cur_q.lo};
                end
                MODE_RELOAD8: begin
                    if (&cur_q.lo) begin
                        cur_d.lo = cur_q.hi;
                        wrap     = 1'b1;
                    end else begin
                        cur_d.lo = cur_q.lo + 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (wrap)           cur_d.flag = 1'b1;
        else if (ack_i)     cur_d.flag = 1'b0;
        else if (flag_wr_i) cur_d.flag = flag_wval_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign lo_o   = cur_q.lo;
    assign hi_o   = cur_q.hi;
    assign flag_o = cur_q.flag;

    // R2: counts move only on strobe edges or by a write
    a_r2_steps_on_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_lo_i && !wr_hi_i) |=> $stable({cur_q.hi, cur_q.lo}));

    // R4: a stopped channel keeps its count
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable({cur_q.hi, cur_q.lo}));

    // R9: halt mode keeps its count
    a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.mode == MODE_HALT && !wr_lo_i && !wr_hi_i)
        |=> $stable({cur_q.hi, cur_q.lo}));

    // R6: a 16-bit wrap lands on zero with the flag up
    a_r6_wrap16: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.mode == MODE_16B && step && !wr_lo_i && !wr_hi_i
         && {cur_q.hi, cur_q.lo} == 16'hffff)
        |=> (cur_q.flag && {cur_q.hi, cur_q.lo} == 16'h0000));

    // R7: reload copies the high byte into the low byte
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i.mode == MODE_RELOAD8 && step && !wr_lo_i && !wr_hi_i
         && cur_q.lo == 8'hff)
        |=> (cur_q.lo == $past(cur_q.hi) && cur_q.flag));

    // R11: acknowledge without a step leaves the flag clear
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !step) |=> !cur_q.flag);

endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
    import tmr_pkg::*;
#(
    parameter int CYC_DIV = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [1:0] ext_evt,
    input  logic [1:0] ext_gate,
    input  logic [1:0] ovf_ack,
    output logic [1:0] ovf_flag
);
    localparam int NUM_CH   = 2;
    localparam int NIB_W    = 4;
    localparam int FLAG_POS = 4;
    localparam logic [2:0] ADDR_CFG  = 3'd0;
    localparam logic [2:0] ADDR_CTRL = 3'd1;

    tmr_top_t top_d, top_q;

    logic                           tick;
    logic [NUM_CH-1:0]              fall;
    logic [NUM_CH-1:0]              flag_w;
    logic [NUM_CH-1:0][BYTE_W-1:0]  lo_w, hi_w;
    logic                           ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    always_comb begin
        top_d = top_q;
        if (reg_wr && reg_addr == ADDR_CFG) top_d.cfg = reg_wdata;
        if (ctrl_wr)                        top_d.run = reg_wdata[NUM_CH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    tmr_tick #(.CYC_DIV(CYC_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    generate
        for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
            localparam logic [2:0] LO_ADDR = 3'(2 + 2 * n);
            localparam logic [2:0] HI_ADDR = 3'(3 + 2 * n);

            tmr_edge u_edge (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick_i (tick),
                .pin_i  (ext_evt[n]),
                .fall_o (fall[n])
            );

            tmr_channel u_chan (
                .clk         (clk),
                .rst_n       (rst_n),
                .cfg_i       (tmr_cfg_t'(top_q.cfg[NIB_W*n +: NIB_W])),
                .run_i       (top_q.run[n]),
                .gate_i      (ext_gate[n]),
                .tick_i      (tick),
                .fall_i      (fall[n]),
                .wr_lo_i     (reg_wr && reg_addr == LO_ADDR),
                .wr_hi_i     (reg_wr && reg_addr == HI_ADDR),
                .wdata_i     (reg_wdata),
                .flag_wr_i   (ctrl_wr),
                .flag_wval_i (reg_wdata[FLAG_POS + n]),
                .ack_i       (ovf_ack[n]),
                .lo_o        (lo_w[n]),
                .hi_o        (hi_w[n]),
                .flag_o      (flag_w[n])
            );

            // R10: a low-byte write shows on the next cycle
            a_r10_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_wr && reg_addr == LO_ADDR) |=> (lo_w[n] == $past(reg_wdata)));
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CFG:  reg_rdata = top_q.cfg;
            ADDR_CTRL: begin
                reg_rdata[NUM_CH-1:0]                = top_q.run;
                reg_rdata[FLAG_POS +: NUM_CH]        = flag_w;
            end
            default: begin
                for (int n = 0; n < NUM_CH; n++) begin
                    if (reg_addr == 3'(2 + 2 * n)) reg_rdata = lo_w[n];
                    if (reg_addr == 3'(3 + 2 * n)) reg_rdata = hi_w[n];
                end
            end
        endcase
    end

    assign ovf_flag = flag_w;

    // R3: configuration write lands in the register
    a_r3_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CFG) |=> (top_q.cfg == $past(reg_wdata)));

endmodule

// File: tb/sim_dual_timer_unit.sv
`timescale 1ns/1ps
module sim_dual_timer_unit;
    localparam int DIV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] ext_evt = '0;
    logic [1:0] ext_gate = '0;
    logic [1:0] ovf_ack = '0;
    logic [1:0] ovf_flag;

    int checks = 0;
    int fails  = 0;
    int e      = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (rst_n) e <= e + 1;

    dual_timer_unit #(.CYC_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_evt(ext_evt),
        .ext_gate(ext_gate), .ovf_ack(ovf_ack), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input int exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic align();
        while (e % DIV != 0) @(negedge clk);
    endtask

    task automatic pre_tick();
        while (e % DIV != DIV - 1) @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(negedge clk);
            while (e % DIV != 0) @(negedge clk);
        end
    endtask

    // count steps for a channel from the requirement rules: {flag,hi,lo}
    function automatic logic [16:0] model(input logic [3:0] nib, input logic [7:0] hi,
                                          input logic [7:0] lo, input int n);
        logic f = 1'b0;
        if (nib[3] || nib[2]) return {f, hi, lo};
        for (int i = 0; i < n; i++) begin
            case (nib[1:0])
                2'd0: begin
                    if (lo[4:0] == 5'h1f) begin
                        lo[4:0] = 5'h0;
                        if (hi == 8'hff) f = 1'b1;
                        hi = hi + 8'd1;
                    end else lo[4:0] = lo[4:0] + 5'd1;
                end
                2'd1: begin
                    if ({hi, lo} == 16'hffff) f = 1'b1;
                    {hi, lo} = {hi, lo} + 16'd1;
                end
                2'd2: begin
                    if (lo == 8'hff) begin lo = hi; f = 1'b1; end
                    else lo = lo + 8'd1;
                end
                default: ;
            endcase
        end
        return {f, hi, lo};
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [16:0] m;
        logic [7:0]  v0, v1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) expect_reg("R1 reset", 3'(a), 0);
        check("R1 flags", ovf_flag, 0);

        // R2 / R6: 16-bit timer, one step per machine cycle, wrap
        align();
        wr(3'd2, 8'hfe); wr(3'd3, 8'hff); wr(3'd0, 8'h01); wr(3'd1, 8'h01);
        expect_reg("R2 no step before strobe", 3'd2, 8'hfe);
        wait_ticks(1);
        expect_reg("R2 one step", 3'd2, 8'hff);
        expect_reg("R2 hi", 3'd3, 8'hff);
        check("R6 no flag yet", ovf_flag[0], 0);
        wait_ticks(1);
        expect_reg("R6 wrap lo", 3'd2, 8'h00);
        expect_reg("R6 wrap hi", 3'd3, 8'h00);
        check("R12 flag pin", ovf_flag[0], 1);
        check("R12 other channel", ovf_flag[1], 0);

        // R11: ack, software set, software clear
        ovf_ack[0] = 1'b1; @(negedge clk); ovf_ack[0] = 1'b0;
        check("R11 ack clears", ovf_flag[0], 0);
        wr(3'd1, 8'h11);
        expect_reg("R11 write sets", 3'd1, 8'h11);
        wr(3'd1, 8'h01);
        check("R11 write clears", ovf_flag[0], 0);

        // R11 collision: ack on the wrapping edge
        align();
        wr(3'd1, 8'h00); wr(3'd2, 8'hff); wr(3'd3, 8'hff); wr(3'd1, 8'h01);
        pre_tick();
        ovf_ack[0] = 1'b1; @(negedge clk); ovf_ack[0] = 1'b0;
        check("R11 overflow beats ack", ovf_flag[0], 1);
        expect_reg("R11 count wrapped", 3'd2, 8'h00);

        // R10 collision: byte write on a strobe edge
        align();
        wr(3'd1, 8'h00); wr(3'd2, 8'h10); wr(3'd3, 8'h20); wr(3'd1, 8'h01);
        pre_tick();
        wr(3'd2, 8'h55);
        expect_reg("R10 write beats step", 3'd2, 8'h55);
        expect_reg("R10 hi kept", 3'd3, 8'h20);
        wait_ticks(1);
        expect_reg("R10 step after write", 3'd2, 8'h56);

        // R7: 8-bit reload
        align();
        wr(3'd1, 8'h00); wr(3'd3, 8'h40); wr(3'd2, 8'hfe); wr(3'd0, 8'h02); wr(3'd1, 8'h01);
        wait_ticks(1);
        expect_reg("R7 lo ff", 3'd2, 8'hff);
        check("R7 no flag", ovf_flag[0], 0);
        wait_ticks(1);
        expect_reg("R7 reloaded", 3'd2, 8'h40);
        expect_reg("R7 hi unchanged", 3'd3, 8'h40);
        check("R7 flag", ovf_flag[0], 1);
        wait_ticks(1);
        expect_reg("R7 counts on", 3'd2, 8'h41);

        // R8: 13-bit count
        align();
        wr(3'd1, 8'h00); wr(3'd3, 8'hff); wr(3'd2, 8'hfe); wr(3'd0, 8'h00); wr(3'd1, 8'h01);
        wait_ticks(1);
        expect_reg("R8 prescale full", 3'd2, 8'hff);
        wait_ticks(1);
        expect_reg("R8 lo wrapped, top bits kept", 3'd2, 8'he0);
        expect_reg("R8 hi wrapped", 3'd3, 8'h00);
        check("R8 flag", ovf_flag[0], 1);

        // R9: halt
        wr(3'd0, 8'h03);
        wait_ticks(3);
        expect_reg("R9 halt lo", 3'd2, 8'he0);
        expect_reg("R9 halt hi", 3'd3, 8'h00);

        // R4: gate and run
        align();
        wr(3'd1, 8'h00); wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
        wait_ticks(2);
        expect_reg("R4 gate low blocks", 3'd2, 8'h00);
        ext_gate[0] = 1'b1;
        wait_ticks(2);
        expect_reg("R4 gate high counts", 3'd2, 8'h02);
        wr(3'd1, 8'h00);
        wait_ticks(2);
        expect_reg("R4 run off holds", 3'd2, 8'h02);
        ext_gate[0] = 1'b0;

        // R5: event counting on sampled falling edges
        align();
        wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
        for (int k = 0; k < 3; k++) begin
            ext_evt[0] = 1'b1; wait_ticks(1);
            ext_evt[0] = 1'b0; wait_ticks(1);
        end
        expect_reg("R5 three events", 3'd2, 8'h03);
        align();
        @(negedge clk); ext_evt[0] = 1'b1;
        @(negedge clk); ext_evt[0] = 1'b0;
        wait_ticks(2);
        expect_reg("R5 short pulse ignored", 3'd2, 8'h03);
        wr(3'd1, 8'h00);

        // R3 / R12: sweep every nibble of channel 1, channel 0 stopped
        rd(3'd2, v0); rd(3'd3, v1);
        for (int nib = 0; nib < 16; nib++) begin
            align();
            wr(3'd0, {4'(nib), 4'h0}); wr(3'd5, 8'hff); wr(3'd4, 8'hfe); wr(3'd1, 8'h02);
            wait_ticks(3);
            m = model(4'(nib), 8'hff, 8'hfe, 3);
            expect_reg($sformatf("R3 ch1 lo nib %0h", nib), 3'd4, m[7:0]);
            expect_reg($sformatf("R3 ch1 hi nib %0h", nib), 3'd5, m[15:8]);
            check($sformatf("R12 ch1 flag nib %0h", nib), ovf_flag[1], m[16]);
        end
        expect_reg("R12 ch0 lo untouched", 3'd2, v0);
        expect_reg("R12 ch0 hi untouched", 3'd3, v1);
        check("R12 ch0 flag untouched", ovf_flag[0], 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule